// File: doc/BRIEF.md
# Selectable-Source Timer Counter with Compare Clear

This block is an 8-bit up-counter for a microcontroller-style timer. It runs on the system clock. It steps only on a one-cycle count enable, and that enable comes from one selected source. One kind of source is a tap of a free-running 7-bit prescaler, which gives six divide ratios from 4 to 128. The other kind is a synchronized external clock pin, counted on its rising edges, its falling edges or both.

Two compare registers, A and B, each raise a sticky match flag. Software clears a flag by writing 1 to its bit. A clear-select field chooses what forces the count back to zero: nothing, a match on A, a match on B, or a rising edge on a synchronized external trigger pin.

A simple write port loads the control fields, the two compare values and the count. A count write takes priority over everything else. After reset the source and clear selections are all zero, so the counter neither counts nor clears until it is configured.

Top module: `count_timer`

## Requirements
- R1: After reset the count is 0, both flags are 0, the source and clear selections are 0, both compare registers hold 255, and the count stays 0 with no further writes.
- R2: When the 3-bit source code (address 0, bits 2:0) is 000 or 100, the count never advances, whatever the extra select bit (address 1, bit 0) and the external clock pin do.
- R3: Source codes 001, 010 and 011 step the count once every 4/8, 16/32 and 64/128 system clocks respectively, with the extra select bit 0 choosing the smaller ratio and 1 the larger. Each step adds exactly 1.
- R4: Source code 101 adds 1 per rising edge of the external clock pin, 110 adds 1 per falling edge, and 111 adds 1 per edge of either kind. The pin passes through a two-flop synchronizer first, and each edge counts exactly once.
- R5: With clearing disabled, the count wraps from 255 to 0.
- R6: With clear-select (address 0, bits 4:3) equal to 01, the count becomes 0 on the cycle after it equals compare A (address 2). It therefore never exceeds compare A.
- R7: With clear-select 10, the count becomes 0 on the cycle after it equals compare B (address 3). A match on compare A does not clear it.
- R8: With clear-select 11, a synchronized rising edge on the trigger pin sets the count to 0. A falling edge on that pin leaves the count unchanged.
- R9: When a count enable and a selected clear occur in the same cycle, the count becomes 0.
- R10: A write to the count (address 4) loads the written value, even when a count enable or a clear occurs in the same cycle.
- R11: Flag A (flag B) is set on the cycle after the count equals compare A (compare B). It stays set until a write to address 5 with bit 0 (bit 1) set. If a match and that write occur in the same cycle, the flag stays set.
- R12: With clear-select 00, a match on a compare register does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 source/clear, 1 extra select, 2 compare A, 3 compare B, 4 count, 5 flag clear |
| wr_data | input | 8 | Write data |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| ext_trig_i | input | 1 | Asynchronous external clear trigger pin |
| count_o | output | 8 | Current count |
| flag_a_o | output | 1 | Sticky compare A match flag |
| flag_b_o | output | 1 | Sticky compare B match flag |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 7-bit prescaler and two synchronizer stages. With an 8-bit count, a sweep of compare values across the whole range and a full wrap take only a few hundred cycles. With a 7-bit prescaler, all six divide ratios can be timed interval by interval, the slowest in about 400 clocks. With the two-stage synchronizer latency fixed, the external edge counting can be checked one edge at a time, and a clock edge can be made to land in the same cycle as a trigger edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_CNT_W = 8;
    localparam int TMR_PSC_W = 7;

    typedef enum logic [1:0] {
        CLR_NONE    = 2'b00,
        CLR_MATCH_A = 2'b01,
        CLR_MATCH_B = 2'b10,
        CLR_TRIG    = 2'b11
    } clr_sel_e;

    typedef enum logic [2:0] {
        ADR_CTRL_A = 3'd0,
        ADR_CTRL_B = 3'd1,
        ADR_CMP_A  = 3'd2,
        ADR_CMP_B  = 3'd3,
        ADR_COUNT  = 3'd4,
        ADR_FLAG   = 3'd5
    } addr_e;

    typedef struct packed {
        clr_sel_e   clr;
        logic [2:0] src;
        logic       ext;
    } ctrl_t;

    // Edge selection for the synchronizer: bit0 rising, bit1 falling
    typedef logic [1:0] edge_sel_t;

    localparam edge_sel_t EDGE_RISE = 2'b01;

    // Prescaler tap index for a source code low pair and extra select bit.
    // Tap k falls every 2^(k+1) clocks, so 4 -> tap 1, 128 -> tap 6.
    function automatic int tap_index(input logic [1:0] code, input logic ext);
        return 2 * int'(code) - 1 + int'(ext);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PSC_W-1:0] psc_o
);
    logic [PSC_W-1:0] psc_q;

    always_ff @(posedge clk) begin
        if (rst) psc_q <= '0;
        else     psc_q <= psc_q + 1'b1;
    end

    assign psc_o = psc_q;
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_i,
    input  tmr_pkg::edge_sel_t  sel_i,
    output logic                edge_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic            now_lvl, old_lvl;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SH_W-2:0], pin_i};
    end

    assign now_lvl = sh_q[STAGES-1];
    assign old_lvl = sh_q[STAGES];
    assign edge_o  = (sel_i[0] & now_lvl & ~old_lvl)
                   | (sel_i[1] & ~now_lvl & old_lvl);
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tmr_pkg::*;
#(
    parameter int PSC_W = 7
) (
    input  logic [2:0]       src_i,
    input  logic             ext_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             ext_edge_i,
    output logic             cnt_en_o
);
    int   idx;
    logic tap_fall;

    always_comb begin
        idx      = tap_index(src_i[1:0], ext_i);
        tap_fall = 1'b1;
        for (int i = 0; i < PSC_W; i++) begin
            if (i <= idx) tap_fall = tap_fall & psc_i[i];
        end
    end

    always_comb begin
        if (src_i[1:0] == 2'b00) cnt_en_o = 1'b0;
        else if (src_i[2])       cnt_en_o = ext_edge_i;
        else                     cnt_en_o = tap_fall;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cnt_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (wr_cnt_i) cnt_q <= wr_val_i;
        else if (clr_i)    cnt_q <= '0;
        else if (en_i)     cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/count_timer.sv
module count_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = TMR_CNT_W,
    parameter int PSC_W       = TMR_PSC_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_clk_i,
    input  logic             ext_trig_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_a_o,
    output logic             flag_b_o
);
    localparam int PINS = 2;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_a_q, cmp_b_q, count_q;
    logic [PSC_W-1:0] psc;
    logic [PINS-1:0]  pin_raw, pin_edge;
    edge_sel_t        pin_sel [PINS];
    logic             cnt_en, clr_hit, wr_cnt;
    logic             match_a, match_b, flag_a_clr, flag_b_clr;
    logic             flag_a_q, flag_b_q;

    // register write port
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{clr: CLR_NONE, src: 3'b000, ext: 1'b0};
            cmp_a_q <= '1;
            cmp_b_q <= '1;
        end else if (wr_en) begin
            case (addr_e'(wr_addr))
                ADR_CTRL_A: begin
                    ctrl_q.clr <= clr_sel_e'(wr_data[4:3]);
                    ctrl_q.src <= wr_data[2:0];
                end
                ADR_CTRL_B: ctrl_q.ext <= wr_data[0];
                ADR_CMP_A:  cmp_a_q    <= wr_data;
                ADR_CMP_B:  cmp_b_q    <= wr_data;
                default: ;
            endcase
        end
    end

    assign wr_cnt     = wr_en && (wr_addr == ADR_COUNT);
    assign flag_a_clr = wr_en && (wr_addr == ADR_FLAG) && wr_data[0];
    assign flag_b_clr = wr_en && (wr_addr == ADR_FLAG) && wr_data[1];

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst   (rst),
        .psc_o (psc)
    );

    // pin 0: external count clock, pin 1: clear trigger
    assign pin_raw    = {ext_trig_i, ext_clk_i};
    assign pin_sel[0] = edge_sel_t'(ctrl_q.src[1:0]);
    assign pin_sel[1] = EDGE_RISE;

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pin_raw[g]),
            .sel_i  (pin_sel[g]),
            .edge_o (pin_edge[g])
        );
    end

    tmr_src_sel #(.PSC_W(PSC_W)) u_src (
        .src_i      (ctrl_q.src),
        .ext_i      (ctrl_q.ext),
        .psc_i      (psc),
        .ext_edge_i (pin_edge[0]),
        .cnt_en_o   (cnt_en)
    );

    assign match_a = (count_q == cmp_a_q);
    assign match_b = (count_q == cmp_b_q);

    always_comb begin
        case (ctrl_q.clr)
            CLR_MATCH_A: clr_hit = match_a;
            CLR_MATCH_B: clr_hit = match_b;
            CLR_TRIG:    clr_hit = pin_edge[1];
            default:     clr_hit = 1'b0;
        endcase
    end

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .wr_cnt_i (wr_cnt),
        .wr_val_i (wr_data),
        .clr_i    (clr_hit),
        .en_i     (cnt_en),
        .count_o  (count_q)
    );

    // sticky flags, a match in the same cycle beats a software clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_a_q <= 1'b0;
            flag_b_q <= 1'b0;
        end else begin
            flag_a_q <= match_a | (flag_a_q & ~flag_a_clr);
            flag_b_q <= match_b | (flag_b_q & ~flag_b_clr);
        end
    end

    assign count_o  = count_q;
    assign flag_a_o = flag_a_q;
    assign flag_b_o = flag_b_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             cnt_en,
    input logic             clr_hit,
    input logic             wr_cnt,
    input logic [CNT_W-1:0] wr_val,
    input logic [1:0]       src_low,
    input logic             flag_a,
    input logic             flag_a_clr
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (src_low == 2'b00 && !clr_hit && !wr_cnt) |=> $stable(count)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !clr_hit && !wr_cnt) |=> count == CNT_W'($past(count) + 1'b1)); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !clr_hit && !wr_cnt) |=> $stable(count)); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (count == '1 && cnt_en && !clr_hit && !wr_cnt) |=> count == '0); // R5

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !wr_cnt) |=> count == '0); // R9

    AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> count == $past(wr_val)); // R10

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag_a && !flag_a_clr) |=> flag_a); // R11
endmodule

bind count_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .count      (count_q),
    .cnt_en     (cnt_en),
    .clr_hit    (clr_hit),
    .wr_cnt     (wr_cnt),
    .wr_val     (wr_data),
    .src_low    (ctrl_q.src[1:0]),
    .flag_a     (flag_a_q),
    .flag_a_clr (flag_a_clr)
);

// File: tb/count_timer_tb_top.sv
module count_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ext_clk_i = 1'b0;
    logic       ext_trig_i = 1'b0;
    logic [7:0] count_o;
    logic       flag_a_o, flag_b_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    count_timer dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ext_clk_i  (ext_clk_i),
        .ext_trig_i (ext_trig_i),
        .count_o    (count_o),
        .flag_a_o   (flag_a_o),
        .flag_b_o   (flag_b_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input logic [1:0] clr, input logic [2:0] src, input logic ext);
        wr(3'd0, {3'b000, clr, src});
        wr(3'd1, {7'b0, ext});
    endtask

    task automatic pulse_ext();
        ext_clk_i = 1'b1; idle(4);
        ext_clk_i = 1'b0; idle(4);
    endtask

    task automatic wait_change(output int n);
        logic [7:0] prev = count_o;
        n = 0;
        while (count_o == prev && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(input int div);
        int n;
        logic [7:0] prev;
        wait_change(n);
        for (int k = 0; k < 3; k++) begin
            prev = count_o;
            wait_change(n);
            check($sformatf("R3 period div%0d", div), n, div);
            check("R3 step of one", int'(count_o), (int'(prev) + 1) % 256);
        end
    endtask

    task automatic track_max(input int cycles, output int mx);
        mx = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (int'(count_o) > mx) mx = int'(count_o);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n, mx;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 count after reset", int'(count_o), 0);
        check("R1 flag A after reset", int'(flag_a_o), 0);
        check("R1 flag B after reset", int'(flag_b_o), 0);
        idle(300);
        check("R1 count idle", int'(count_o), 0);

        // R2: no-source codes with both extra-bit values
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 2; e++) begin
                set_ctrl(2'b00, (s == 0) ? 3'b000 : 3'b100, e[0]);
                wr(3'd4, 8'd5);
                pulse_ext(); pulse_ext();
                idle(300);
                check("R2 hold", int'(count_o), 5);
            end
        end

        // R3: all six prescale ratios
        for (int c = 1; c < 4; c++) begin
            for (int e = 0; e < 2; e++) begin
                set_ctrl(2'b00, c[2:0], e[0]);
                measure(1 << (2 * c + e));
            end
        end

        // R4: external edge modes
        set_ctrl(2'b00, 3'b101, 1'b0);
        wr(3'd4, 8'd0);
        repeat (5) pulse_ext();
        check("R4 rising edges", int'(count_o), 5);
        set_ctrl(2'b00, 3'b110, 1'b0);
        wr(3'd4, 8'd0);
        ext_clk_i = 1'b1; idle(4);
        check("R4 falling mode ignores rise", int'(count_o), 0);
        ext_clk_i = 1'b0; idle(4);
        check("R4 falling mode counts fall", int'(count_o), 1);
        repeat (4) pulse_ext();
        check("R4 falling edges", int'(count_o), 5);
        set_ctrl(2'b00, 3'b111, 1'b0);
        wr(3'd4, 8'd0);
        repeat (5) pulse_ext();
        check("R4 both edges", int'(count_o), 10);

        // R5: wrap
        set_ctrl(2'b00, 3'b001, 1'b0);
        wr(3'd4, 8'd254);
        if (count_o == 8'd254) wait_change(n);
        check("R5 reaches 255", int'(count_o), 255);
        wait_change(n);
        check("R5 wraps to 0", int'(count_o), 0);

        // R12: clear disabled, matches do not clear
        wr(3'd2, 8'd3);
        wr(3'd3, 8'd9);
        wr(3'd4, 8'd0);
        idle(60);
        check("R12 count passes compare", int'(count_o >= 8'd12), 1);
        check("R11 flag A set by match", int'(flag_a_o), 1);
        wr(3'd5, 8'd3);

        // R6: clear on match A
        set_ctrl(2'b01, 3'b001, 1'b0);
        wr(3'd4, 8'd0);
        track_max(200, mx);
        check("R6 max equals compare A", mx, 3);

        // R7: clear on match B, match A ignored
        set_ctrl(2'b10, 3'b001, 1'b0);
        wr(3'd4, 8'd0);
        track_max(200, mx);
        check("R7 max equals compare B", mx, 9);

        // R8: trigger edge clear, falling edge ignored
        set_ctrl(2'b11, 3'b000, 1'b0);
        wr(3'd4, 8'd77);
        ext_trig_i = 1'b1; idle(5);
        check("R8 trigger rise clears", int'(count_o), 0);
        wr(3'd4, 8'd77);
        ext_trig_i = 1'b0; idle(5);
        check("R8 trigger fall ignored", int'(count_o), 77);

        // R9: clock edge and trigger rise in the same cycle
        set_ctrl(2'b11, 3'b111, 1'b0);
        wr(3'd4, 8'd40);
        ext_clk_i = 1'b1; ext_trig_i = 1'b1; idle(5);
        check("R9 clear beats count", int'(count_o), 0);
        ext_clk_i = 1'b0; ext_trig_i = 1'b0; idle(5);
        check("R9 fall counts", int'(count_o), 1);
        ext_clk_i = 1'b1; ext_trig_i = 1'b1; idle(5);
        check("R9 clear beats count again", int'(count_o), 0);
        ext_clk_i = 1'b0; ext_trig_i = 1'b0; idle(5);

        // R10: write beats a pending match clear
        set_ctrl(2'b01, 3'b000, 1'b0);
        wr(3'd2, 8'd20);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'd20;
        @(negedge clk);
        check("R10 write loads", int'(count_o), 20);
        wr_data = 8'd33;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 write beats clear", int'(count_o), 33);
        idle(2);
        check("R10 value kept", int'(count_o), 33);

        // R11: flag sweep over compare values
        set_ctrl(2'b00, 3'b000, 1'b0);
        wr(3'd3, 8'd126);
        wr(3'd5, 8'd3);
        for (int v = 0; v < 256; v += 17) begin
            wr(3'd2, v[7:0]);
            wr(3'd4, v[7:0]);
            idle(1);
            check("R11 flag A set", int'(flag_a_o), 1);
            check("R11 flag B untouched", int'(flag_b_o), 0);
            wr(3'd5, 8'd1);
            check("R11 match beats clear", int'(flag_a_o), 1);
            wr(3'd4, 8'(v + 1));
            wr(3'd5, 8'd1);
            check("R11 flag A cleared", int'(flag_a_o), 0);
        end
        wr(3'd4, 8'd126);
        idle(1);
        check("R11 flag B set", int'(flag_b_o), 1);
        wr(3'd4, 8'd0);
        wr(3'd5, 8'd2);
        check("R11 flag B cleared", int'(flag_b_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule